// File: doc/BRIEF.md
# RTD Converter SPI Poller

This block is an SPI master for an external resistance-to-digital temperature converter. After reset it performs one register write that sets up the converter. Then it reads the converter's whole register file in one burst, over and over, without stopping. From each burst it takes the 16-bit data word and splits it into a 15-bit resistance code and a fault flag. It then scales the code into ohms, using a reference resistor value set at elaboration time.

The host sees three results: the raw code, the fault flag and a fixed-point resistance with 4 fractional bits. A one-cycle strobe marks each fresh sample. The results hold their value until the next burst completes. A parameter chooses the sensor wiring mode, which is placed in the configuration byte. A second parameter sets the SCK rate as a division of the system clock.

Top module: `rtd_spi_poller`

## Requirements
- R1: The first transaction after reset is exactly two bytes. The first byte is 0x80, a write to register 0. The second is the configuration byte, which is 0xA2 with the default parameters.
- R2: The parameter THREE_WIRE sets bit 4 of the configuration byte when it is 1, giving 0xB2. When it is 0, bit 4 is clear, giving 0xA2. All other configuration bits stay fixed.
- R3: Every later transaction is a 9-byte burst whose first transmitted byte is 0x00. The byte received while that address goes out is a dummy and is discarded. Bursts repeat without end.
- R4: Received bytes are counted from 0 within the burst. Byte 2 is the high half of the data word and byte 3 is the low half. The resistance code output equals bits 15..1 of that word. Bytes 1 and 4 to 8 do not affect any output.
- R5: The fault output equals bit 0 of the data word.
- R6: The resistance output equals floor(code × RREF × 16 / 8192), which is code × RREF / 8192 with 4 fractional bits. RREF defaults to 430.
- R7: The sample strobe is high for exactly one cycle per completed burst. It rises in the same cycle that chip select deasserts, and new outputs appear in that same cycle. Outputs do not change between strobes, and no strobe follows the configuration write.
- R8: The SPI link runs in mode 1 with the MSB first. SCK idles low. MOSI changes only on a rising SCK edge, and MISO is sampled on the falling edge. One SCK period is 2 × CLK_DIV clocks.
- R9: Chip select is low for the whole of each transaction. Between transactions it stays high for at least GAP_SCK SCK periods (default 2).
- R10: During reset, chip select is high, SCK is low, the strobe is low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_miso | input | 1 | Serial data from the converter |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_cs_n | output | 1 | Active-low chip select |
| rtd_code | output | 15 | Raw resistance code |
| rtd_fault | output | 1 | Fault flag taken from the data word LSB |
| res_q4 | output | RES_W (15 by default) | Resistance in ohms, 4 fractional bits |
| sample_valid | output | 1 | One-cycle strobe per completed burst |

## Verification
The converter model returns a dummy byte of 0xFF and threshold bytes of 0x7FFF and 0x0000 around the data word. A design that took its word from the wrong byte position would therefore report codes built from those bytes. The data words cover all ones, all zeros, a lone LSB and mixed values. These catch a missing right shift, a swapped fault bit and a multiply that overflows at the largest code. The bench counts the clocks that chip select stays high, watches SCK while chip select is high, and rebuilds each MOSI byte on falling SCK edges. A wrong clock phase, an LSB-first shifter or a short inter-transaction gap would each garble a command byte or trip the gap count. A second instance with the three-wire setting must send 0xB2 in place of 0xA2.

// File: rtl/rtd_poll_pkg.sv
package rtd_poll_pkg;
  localparam int BYTE_W       = 8;
  localparam int WORD_W       = 16;
  localparam int CODE_W       = 15;
  localparam int BURST_BYTES  = 9;
  localparam int CFG_BYTES    = 2;
  localparam int IDX_W        = 4;
  localparam int WORD_HI_POS  = 2;
  localparam int WORD_LO_POS  = 3;
  localparam int WIRE_BIT     = 4;
  // 8192 divided by 16 (four fractional bits kept)
  localparam int SCALE_SHIFT  = 9;

  localparam logic [BYTE_W-1:0] CMD_WRITE_CFG = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_READ_ALL  = 8'h00;
  localparam logic [BYTE_W-1:0] CFG_BASE      = 8'hA2;

  typedef enum logic [1:0] {
    SQ_GAP,
    SQ_LAUNCH,
    SQ_SHIFT,
    SQ_CLOSE
  } seq_state_t;

  function automatic logic [BYTE_W-1:0] cfg_byte(input bit three_wire);
    logic [BYTE_W-1:0] v;
    v = CFG_BASE;
    v[WIRE_BIT] = three_wire;
    return v;
  endfunction
endpackage

// File: rtl/rtd_spi_shifter.sv
module rtd_spi_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic             active_q, active_d;
  logic             phase_q, phase_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic             sck_q, sck_d;
  logic             mosi_q, mosi_d;
  logic             done_q, done_d;
  logic             half_end;

  assign half_end = (cnt_q == DIV_W'(CLK_DIV - 1));

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    sck_d    = sck_q;
    mosi_d   = mosi_q;
    done_d   = 1'b0;
    if (start_i && !active_q) begin
      active_d = 1'b1;
      phase_d  = 1'b0;
      cnt_d    = '0;
      bit_d    = '0;
      tx_d     = tx_i;
    end else if (active_q) begin
      if (!half_end) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        if (!phase_q) begin
          // rising edge: launch next data bit
          sck_d   = 1'b1;
          mosi_d  = tx_q[7];
          phase_d = 1'b1;
        end else begin
          // falling edge: capture returned bit
          sck_d   = 1'b0;
          rx_d    = {rx_q[6:0], miso_i};
          tx_d    = {tx_q[6:0], 1'b0};
          phase_d = 1'b0;
          if (bit_q == 3'd7) begin
            active_d = 1'b0;
            done_d   = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      bit_q    <= bit_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      sck_q    <= sck_d;
      mosi_q   <= mosi_d;
      done_q   <= done_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R8: a finished byte is reported only right after the final falling edge
  a_r8_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(sck_q));
  // R8: MOSI only moves together with a rising SCK
  a_r8_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi_q != $past(mosi_q)) |-> $rose(sck_q));
endmodule

// File: rtl/rtd_res_scale.sv
module rtd_res_scale
  import rtd_poll_pkg::*;
#(
  parameter int RREF   = 430,
  parameter int RREF_W = 9,
  parameter int RES_W  = 15
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              fault_o,
  output logic [RES_W-1:0]  res_o
);
  localparam int PROD_W = CODE_W + RREF_W;

  logic [PROD_W-1:0] prod;

  assign code_o  = word_i[WORD_W-1:1];
  assign fault_o = word_i[0];
  assign prod    = PROD_W'(code_o) * PROD_W'(RREF);
  assign res_o   = prod[PROD_W-1:SCALE_SHIFT];
endmodule

// File: rtl/rtd_poll_seq.sv
module rtd_poll_seq
  import rtd_poll_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int GAP_SCK    = 2,
  parameter bit THREE_WIRE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [7:0]        rx_i,
  output logic              start_o,
  output logic [7:0]        tx_o,
  output logic              cs_n_o,
  output logic [WORD_W-1:0] word_o,
  output logic              poll_done_o
);
  localparam int GAP_CYC = GAP_SCK * 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [7:0] CFG_WORD = cfg_byte(THREE_WIRE);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cfg_done_q, cfg_done_d;
  logic             cs_n_q, cs_n_d;
  logic [7:0]       hi_q, hi_d, lo_q, lo_d;

  assign last_idx = cfg_done_q ? IDX_W'(BURST_BYTES - 1) : IDX_W'(CFG_BYTES - 1);

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    gap_d       = gap_q;
    cfg_done_d  = cfg_done_q;
    cs_n_d      = cs_n_q;
    hi_d        = hi_q;
    lo_d        = lo_q;
    start_o     = 1'b0;
    poll_done_o = 1'b0;
    if (cfg_done_q)          tx_o = CMD_READ_ALL;
    else if (idx_q == '0)    tx_o = CMD_WRITE_CFG;
    else                     tx_o = CFG_WORD;
    case (state_q)
      SQ_GAP: begin
        if (gap_q == GAP_W'(GAP_CYC - 1)) begin
          gap_d   = '0;
          cs_n_d  = 1'b0;
          state_d = SQ_LAUNCH;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      SQ_LAUNCH: begin
        start_o = 1'b1;
        state_d = SQ_SHIFT;
      end
      SQ_SHIFT: begin
        if (done_i) begin
          if (cfg_done_q && idx_q == IDX_W'(WORD_HI_POS)) hi_d = rx_i;
          if (cfg_done_q && idx_q == IDX_W'(WORD_LO_POS)) lo_d = rx_i;
          if (idx_q == last_idx) begin
            state_d = SQ_CLOSE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = SQ_LAUNCH;
          end
        end
      end
      SQ_CLOSE: begin
        cs_n_d      = 1'b1;
        poll_done_o = cfg_done_q;
        cfg_done_d  = 1'b1;
        idx_d       = '0;
        state_d     = SQ_GAP;
      end
      default: state_d = SQ_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_GAP;
      idx_q      <= '0;
      gap_q      <= '0;
      cfg_done_q <= 1'b0;
      cs_n_q     <= 1'b1;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      gap_q      <= gap_d;
      cfg_done_q <= cfg_done_d;
      cs_n_q     <= cs_n_d;
      hi_q       <= hi_d;
      lo_q       <= lo_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign word_o = {hi_q, lo_q};

  // checker-only count of cycles spent with chip select high
  logic [GAP_W-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_run_q <= '0;
    else if (!cs_n_q)                    hi_run_q <= '0;
    else if (hi_run_q != GAP_W'(GAP_CYC)) hi_run_q <= hi_run_q + 1'b1;
  end

  // R9: chip select is idle for the full gap before each assertion
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (hi_run_q == GAP_W'(GAP_CYC)));
  // R9: bytes are only launched inside an active chip select window
  a_r9_start_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !cs_n_q);
endmodule

// File: rtl/rtd_spi_poller.sv
module rtd_spi_poller
  import rtd_poll_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int GAP_SCK    = 2,
  parameter bit THREE_WIRE = 1'b0,
  parameter int RREF       = 430,
  localparam int RREF_W    = $clog2(RREF + 1),
  localparam int RES_W     = CODE_W + RREF_W - SCALE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic [CODE_W-1:0] rtd_code,
  output logic              rtd_fault,
  output logic [RES_W-1:0]  res_q4,
  output logic              sample_valid
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic              start, done, poll_done;
  logic [7:0]        tx_byte, rx_byte;
  logic [WORD_W-1:0] word;
  logic [CODE_W-1:0] code_c, code_q;
  logic              fault_c, fault_q;
  logic [RES_W-1:0]  res_c, res_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  rtd_poll_seq #(
    .CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK), .THREE_WIRE(THREE_WIRE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n_s), .done_i(done), .rx_i(rx_byte),
    .start_o(start), .tx_o(tx_byte), .cs_n_o(spi_cs_n),
    .word_o(word), .poll_done_o(poll_done)
  );

  rtd_spi_shifter #(.CLK_DIV(CLK_DIV)) shf_i (
    .clk(clk), .rst_n(rst_n_s), .start_i(start), .tx_i(tx_byte),
    .miso_i(spi_miso), .sck_o(spi_sck), .mosi_o(spi_mosi),
    .done_o(done), .rx_o(rx_byte)
  );

  rtd_res_scale #(.RREF(RREF), .RREF_W(RREF_W), .RES_W(RES_W)) scl_i (
    .word_i(word), .code_o(code_c), .fault_o(fault_c), .res_o(res_c)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      code_q  <= '0;
      fault_q <= 1'b0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= poll_done;
      if (poll_done) begin
        code_q  <= code_c;
        fault_q <= fault_c;
        res_q   <= res_c;
      end
    end
  end

  assign rtd_code     = code_q;
  assign rtd_fault    = fault_q;
  assign res_q4       = res_q;
  assign sample_valid = valid_q;

  // R7: strobe lasts a single cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_q |=> !valid_q);
  // R7: results are frozen between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !valid_q |-> ($stable(code_q) && $stable(fault_q) && $stable(res_q)));
  // R8: serial clock rests low whenever the converter is deselected
  a_r8_sck_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    spi_cs_n |-> !spi_sck);
  // R7: a strobe coincides with chip select going inactive
  a_r7_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_q |-> $rose(spi_cs_n));
endmodule

// File: tb/rtd_spi_poller_tb.sv
`timescale 1ns/1ps
module rtd_spi_poller_tb_top;
  localparam int CLK_DIV = 2;
  localparam int GAP_SCK = 2;
  localparam int RREF    = 430;
  localparam int NPOLL   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_miso;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic [14:0] rtd_code;
  logic        rtd_fault;
  logic [14:0] res_q4;
  logic        sample_valid;

  logic        miso3;
  logic        sck3, mosi3, cs3;
  logic [14:0] code3, res3;
  logic        fault3, valid3;

  always #2 clk = ~clk;

  rtd_spi_poller #(.CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK), .THREE_WIRE(1'b0), .RREF(RREF)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .rtd_code(rtd_code),
    .rtd_fault(rtd_fault), .res_q4(res_q4), .sample_valid(sample_valid)
  );

  rtd_spi_poller #(.CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK), .THREE_WIRE(1'b1), .RREF(RREF)) dut_3w (
    .clk(clk), .rst_n(rst_n), .spi_miso(miso3), .spi_sck(sck3),
    .spi_mosi(mosi3), .spi_cs_n(cs3), .rtd_code(code3),
    .rtd_fault(fault3), .res_q4(res3), .sample_valid(valid3)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model
  logic [15:0] pat [6] = '{16'h4119, 16'hFFFE, 16'h0000, 16'h0001, 16'hA3A4, 16'h2000};
  int          bit_i = 0;
  int          txn_n = 0;
  logic [15:0] cur_word = 16'h0;
  logic [7:0]  mosi_b [16];
  logic [7:0]  shin = 8'h0;
  logic [7:0]  fb;

  function automatic logic [7:0] frame_byte(input int k, input logic [15:0] w);
    case (k)
      0: return 8'hFF;      // dummy, must be dropped
      1: return 8'hA2;      // config readback
      2: return w[15:8];
      3: return w[7:0];
      4: return 8'h7F;      // high threshold
      5: return 8'hFF;
      6: return 8'h00;      // low threshold
      7: return 8'h00;
      8: return 8'h00;      // fault status
      default: return 8'h5A;
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge spi_cs_n);
      bit_i = 0;
      cur_word = pat[txn_n % 6];
      txn_n++;
    end
  end

  initial begin
    spi_miso = 1'b0;
    forever begin
      @(posedge spi_sck);
      if (!spi_cs_n) begin
        fb = frame_byte(bit_i / 8, cur_word);
        spi_miso = fb[7 - (bit_i % 8)];
      end
    end
  end

  initial begin
    forever begin
      @(negedge spi_sck);
      if (!spi_cs_n) begin
        shin = {shin[6:0], spi_mosi};
        bit_i++;
        if ((bit_i % 8) == 0 && (bit_i / 8) <= 16) mosi_b[bit_i / 8 - 1] = shin;
      end
    end
  end

  // three-wire instance: capture its first 16 MOSI bits (R2)
  logic [15:0] sh3 = 16'h0;
  initial begin
    miso3 = 1'b0;
    wait (rst_n === 1'b1);
    for (int i = 0; i < 16; i++) begin
      @(negedge sck3);
      sh3 = {sh3[14:0], mosi3};
    end
    check("R2 three-wire config write", {16'h0, sh3}, 32'h80B2);
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // main sequence and per-clock reference comparison
  initial begin
    bit   prev_cs;
    int   hi_len;
    int   txn_done;
    int   polls;
    bit   exp_valid;
    int   exp_code, exp_res;
    bit   exp_fault;
    prev_cs = 1'b1; hi_len = 0; txn_done = 0; polls = 0;
    exp_code = 0; exp_res = 0; exp_fault = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 reset cs_n", {31'h0, spi_cs_n}, 32'h1);
    check("R10 reset sck", {31'h0, spi_sck}, 32'h0);
    check("R10 reset valid", {31'h0, sample_valid}, 32'h0);
    check("R10 reset code", {17'h0, rtd_code}, 32'h0);
    check("R10 reset fault", {31'h0, rtd_fault}, 32'h0);
    check("R10 reset res", {17'h0, res_q4}, 32'h0);
    rst_n = 1'b1;
    while (polls < NPOLL) begin
      @(negedge clk);
      exp_valid = 1'b0;
      if (prev_cs && !spi_cs_n)
        check("R9 cs high gap long enough", {31'h0, hi_len >= 2 * GAP_SCK * CLK_DIV}, 32'h1);
      if (!prev_cs && spi_cs_n) begin
        check("R8 whole bytes per transaction", bit_i % 8, 0);
        if (txn_done == 0) begin
          check("R1 write length", bit_i / 8, 2);
          check("R1 write command", {24'h0, mosi_b[0]}, 32'h80);
          check("R1 config byte", {24'h0, mosi_b[1]}, 32'hA2);
        end else begin
          check("R3 burst length", bit_i / 8, 9);
          check("R3 burst address", {24'h0, mosi_b[0]}, 32'h00);
          exp_valid = 1'b1;
          exp_code  = int'(cur_word[15:1]);
          exp_fault = cur_word[0];
          exp_res   = (exp_code * RREF) / 512;
          polls++;
        end
        txn_done++;
      end
      hi_len = spi_cs_n ? hi_len + 1 : 0;
      if (spi_cs_n) check("R8 sck idle low", {31'h0, spi_sck}, 32'h0);
      check("R7 strobe timing", {31'h0, sample_valid}, {31'h0, exp_valid});
      check("R4 code", {17'h0, rtd_code}, exp_code);
      check("R5 fault", {31'h0, rtd_fault}, {31'h0, exp_fault});
      check("R6 resistance", {17'h0, res_q4}, exp_res);
      prev_cs = spi_cs_n;
    end
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule